// File: doc/BRIEF.md
# Banked-Coefficient Time-Shared FIR Filter

This block filters a stream of signed samples with a finite impulse response of fixed length. The coefficients are not built into the logic. They are held in a small writable store divided into banks, and each bank holds one complete coefficient set. A write port updates any single coefficient word at any time, including while a result is being computed. A select input picks which bank the next result uses, so switching between prepared responses needs no reload.

A single multiplier and accumulator serve every tap. The block takes one accepted sample and then needs one clock per tap to form the output. During that time it drops `ready`, and it accepts a new sample only when `ready` is high again. The delay line is a ring of the most recent samples. The newest sample meets coefficient 0 and the oldest meets coefficient TAPS-1.

Top module: `fir_mac_banked`

## Requirements
- R1: After reset `ready` is 1, `out_valid` is 0 and `out_data` is 0. Every coefficient and every stored sample is zero, so the first results reflect zero history and zero coefficients until writes occur.
- R2: Each result equals the sum over k = 0..TAPS-1 of x[n-k]·c[b][k], where x[n] is the sample just accepted, c[b] is the bank selected for it, and samples not yet received count as 0. All values are two's complement.
- R3: A sample is accepted on a rising edge where `in_valid` and `ready` are both 1. `out_valid` is then 1 for exactly one cycle, following the TAPS-th rising edge after the accepting edge.
- R4: `ready` is 0 from the accepting edge until the edge that raises `out_valid`. `in_valid` pulses while `ready` is 0 are ignored and store no sample.
- R5: When `coef_we` is 1 on a rising edge, `coef_data` is stored as tap `coef_tap` of bank `coef_bank`. The new value is used by every computation accepted after that edge.
- R6: `bank_sel` is sampled only at the accepting edge. Changing it while `ready` is 0 has no effect on the result in progress.
- R7: The banks are independent. Writing one bank never changes the results produced with another bank.
- R8: A write to the active bank during a computation gives that single result either the old or the new value of the written word, never a mix of the two.
- R9: The accumulator is SW+CW+ceil(log2 TAPS) bits wide and does not overflow, even for full-scale negative samples and coefficients. `out_data` is the accumulator's top OUT_W bits, which is the sum shifted right arithmetically by (accumulator width − OUT_W).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample offered |
| in_data | input | SW | Signed input sample |
| ready | output | 1 | Block is idle and can take a sample |
| bank_sel | input | max(1,ceil(log2 BANKS)) | Coefficient bank for the next accepted sample |
| coef_we | input | 1 | Coefficient write strobe |
| coef_bank | input | max(1,ceil(log2 BANKS)) | Bank of the written coefficient |
| coef_tap | input | max(1,ceil(log2 TAPS)) | Tap index of the written coefficient |
| coef_data | input | CW | Signed coefficient value |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| out_data | output | OUT_W | Truncated signed filter result |

## Verification
A sample accepted at edge E0 makes `ready` read 0 at the falling edge after E0. `out_valid` must stay 0 at the falling edges after E1 to E(TAPS-1) and must read 1, with the final value, at the falling edge after E(TAPS). The bench checks at exactly those falling edges. Coefficient writes take effect at the edge that samples them, so the bench drives each write at a falling edge before any push that depends on it. A write issued one cycle into a computation is accepted with either the old or the new expected sum. Mid-computation pulses on `in_valid` and changes to `bank_sel` are applied at the first busy falling edge, and the result due TAPS edges after acceptance shows whether they had any effect.

// File: rtl/fir_mac_banked.sv
module fir_mac_banked #(
  parameter int TAPS  = 4,
  parameter int SW    = 8,
  parameter int CW    = 8,
  parameter int BANKS = 2,
  parameter int OUT_W = 16,
  localparam int TW = (TAPS > 1) ? $clog2(TAPS) : 1,
  localparam int BW = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int AW = SW + CW + TW
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [SW-1:0]    in_data,
  output logic                    ready,
  input  logic [BW-1:0]           bank_sel,
  input  logic                    coef_we,
  input  logic [BW-1:0]           coef_bank,
  input  logic [TW-1:0]           coef_tap,
  input  logic signed [CW-1:0]    coef_data,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);
  localparam int PW = SW + CW;

  logic signed [SW-1:0] hist [TAPS];
  logic signed [CW-1:0] coef [BANKS][TAPS];
  logic [TW-1:0] wr_ptr, rd_ptr, idx;
  logic [BW-1:0] act_bank;
  logic          busy;
  logic signed [AW-1:0] acc;

  wire accept = in_valid && !busy;
  wire last   = (idx == TW'(TAPS - 1));
  wire signed [PW-1:0] prod = hist[rd_ptr] * coef[act_bank][idx];
  wire signed [AW-1:0] acc_nxt = acc + {{(AW-PW){prod[PW-1]}}, prod};

  assign ready = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < BANKS; b++)
        for (int t = 0; t < TAPS; t++)
          coef[b][t] <= '0;
    end else if (coef_we && (int'(coef_bank) < BANKS) && (int'(coef_tap) < TAPS)) begin
      coef[coef_bank][coef_tap] <= coef_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < TAPS; t++) hist[t] <= '0;
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      idx       <= '0;
      act_bank  <= '0;
      busy      <= 1'b0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (accept) begin
        hist[wr_ptr] <= in_data;
        rd_ptr       <= wr_ptr;
        wr_ptr       <= (wr_ptr == TW'(TAPS - 1)) ? '0 : wr_ptr + 1'b1;
        act_bank     <= bank_sel;
        idx          <= '0;
        acc          <= '0;
        busy         <= 1'b1;
      end else if (busy) begin
        acc    <= acc_nxt;
        idx    <= idx + 1'b1;
        rd_ptr <= (rd_ptr == '0) ? TW'(TAPS - 1) : rd_ptr - 1'b1;
        if (last) begin
          busy      <= 1'b0;
          out_valid <= 1'b1;
          out_data  <= acc_nxt[AW-1 -: OUT_W];
        end
      end
    end
  end

  // R4
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ready) |=> !ready);

  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ready);

  // R3
  pulse_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(!ready));

  // R6
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> $stable(act_bank));

  // R3
  tap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(idx) < TAPS));
endmodule

// File: tb/fir_mac_banked_tb_top.sv
module fir_mac_banked_tb_top;
  localparam int TAPS = 4, SW = 8, CW = 8, BANKS = 2, OUT_W = 16;
  localparam int AW = SW + CW + 2;
  localparam int SH = AW - OUT_W;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, coef_we = 0;
  logic signed [SW-1:0] in_data = '0;
  logic signed [CW-1:0] coef_data = '0;
  logic [0:0] bank_sel = '0, coef_bank = '0;
  logic [1:0] coef_tap = '0;
  logic ready, out_valid;
  logic signed [OUT_W-1:0] out_data;

  fir_mac_banked #(.TAPS(TAPS), .SW(SW), .CW(CW), .BANKS(BANKS), .OUT_W(OUT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .ready(ready),
    .bank_sel(bank_sel), .coef_we(coef_we), .coef_bank(coef_bank), .coef_tap(coef_tap),
    .coef_data(coef_data), .out_valid(out_valid), .out_data(out_data));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int hm [TAPS];
  int cm [BANKS][TAPS];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model_out(input int b);
    int s = 0;
    for (int k = 0; k < TAPS; k++) s += hm[k] * cm[b][k];
    return s >>> SH;
  endfunction

  task automatic wcoef(input int b, input int t, input int v);
    coef_we = 1; coef_bank = b[0:0]; coef_tap = t[1:0]; coef_data = v[CW-1:0];
    @(posedge clk); @(negedge clk);
    coef_we = 0;
    cm[b][t] = v;
  endtask

  // mid: 0 none, 1 stray in_valid, 2 bank_sel change, 3 coefficient write to active bank tap 0
  task automatic push(input int v, input int b, input int mid, input string req);
    int exp_a, exp_b, got;
    in_valid = 1; in_data = v[SW-1:0]; bank_sel = b[0:0];
    @(posedge clk);
    for (int k = TAPS - 1; k > 0; k--) hm[k] = hm[k-1];
    hm[0] = v;
    exp_a = model_out(b);
    exp_b = exp_a;
    @(negedge clk);
    in_valid = 0;
    check(ready == 0, "R4 ready low after accept", ready, 0);
    if (mid == 1) begin in_valid = 1; in_data = 8'sd99; end
    if (mid == 2) bank_sel = ~b[0:0];
    if (mid == 3) begin
      coef_we = 1; coef_bank = b[0:0]; coef_tap = 0; coef_data = 8'sd77;
      cm[b][0] = 77;
      exp_b = model_out(b);
    end
    for (int i = 1; i <= TAPS; i++) begin
      @(negedge clk);
      in_valid = 0; coef_we = 0;
      if (i < TAPS) begin
        check(out_valid == 0, "R3 no early strobe", out_valid, 0);
        check(ready == 0, "R4 busy holds ready low", ready, 0);
      end
    end
    got = int'(out_data);
    check(out_valid == 1, "R3 strobe after TAPS edges", out_valid, 1);
    check(ready == 1, "R4 ready back with result", ready, 1);
    check(got == exp_a || got == exp_b, req, got, exp_a);
    @(negedge clk);
    check(out_valid == 0, "R3 strobe one cycle", out_valid, 0);
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < TAPS; k++) begin
      hm[k] = 0;
      for (int b = 0; b < BANKS; b++) cm[b][k] = 0;
    end
    repeat (3) @(negedge clk);
    // R1
    check(ready == 1, "R1 ready at reset", ready, 1);
    check(out_valid == 0, "R1 out_valid at reset", out_valid, 0);
    check(out_data == 0, "R1 out_data at reset", out_data, 0);
    rst_n = 1;
    @(negedge clk);
    push(100, 0, 0, "R1 zero coefficients give zero");
    push(-50, 1, 0, "R1 zero coefficients bank1");
    // R5 load and impulse
    wcoef(0, 0, 17); wcoef(0, 1, -5); wcoef(0, 2, 100); wcoef(0, 3, -128);
    wcoef(1, 0, 127); wcoef(1, 1, -128); wcoef(1, 2, 1); wcoef(1, 3, -1);
    push(64, 0, 0, "R5 impulse head");
    for (int i = 0; i < 4; i++) push(0, 0, 0, "R5 impulse tail");
    // R2 R7 sweep of every sample value, alternating banks
    for (int v = -128; v < 128; v++) push(v, (v & 1), 0, "R2 R7 sweep");
    // R4 stray valid while busy ignored
    for (int i = 0; i < 5; i++) push(i * 37 - 60, 0, 1, "R4 stray valid ignored");
    // R6 bank change mid computation
    for (int i = 0; i < 5; i++) push(i * 23 - 40, i % 2, 2, "R6 bank held");
    // R8 write active bank during computation
    push(90, 0, 3, "R8 old or new coefficient");
    push(-33, 0, 0, "R8 new coefficient in later result");
    // R7 writing bank1 leaves bank0 results
    wcoef(1, 2, -77);
    push(12, 0, 0, "R7 bank0 unaffected");
    // R9 full-scale extremes
    for (int t = 0; t < TAPS; t++) wcoef(1, t, -128);
    for (int i = 0; i < 4; i++) push(-128, 1, 0, "R9 max positive sum");
    for (int t = 0; t < TAPS; t++) wcoef(1, t, 127);
    for (int i = 0; i < 4; i++) push(-128, 1, 0, "R9 max negative sum");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule